// File: doc/BRIEF.md
# FPU State Save Sequencer

This block dumps the architectural state of a floating-point unit to memory and then puts that state back to its power-on defaults. A one-cycle start pulse brings a byte base address, an operand-size select (16-bit or 32-bit image) and a flag that picks the checking variant or the no-wait variant. The block waits until the floating-point pipeline reports that all earlier operations have retired. It then evaluates the fault conditions. If none applies, it streams the environment words and then the eight 80-bit stack registers through a 16-bit memory write port with valid/ready handshaking.

Once the final write has been accepted, the sequencer pulses a load strobe. The strobe carries the default values for the control, status, tag, pointer and opcode registers. Done pulses in the same cycle. A fault ends the sequence with a fault code, and in that case there are no writes and no load strobe.

The state being saved comes from a register-file stub on input ports. That stub must hold the state steady while the sequence is busy.

Top module: `fsd_state_dump`

## Requirements
- R1: A start pulse is accepted only while busy_o is low. busy_o rises in the cycle after acceptance and stays high up to and including the done cycle. Start pulses that arrive while busy_o is high have no effect on the address, the size or the variant in use.
- R2: After acceptance, no fault is decided and no write is issued until fpu_idle_i is seen high.
- R3: If bit 2 or bit 3 of cr_i is set, the sequence ends with fault_code_o = 01 (device not available) and no write. This fault has priority over the math fault.
- R4: When chk_wait_i is 1 and pend_unmasked_i is 1, the sequence ends with fault_code_o = 10 (math fault) and no write. When chk_wait_i is 0, pend_unmasked_i has no effect.
- R5: The 16-bit image is 47 word writes (94 bytes). Word k goes to base + 2k. The environment words are, in order: control, status, tag, data pointer bits 15:0, instruction pointer bits 15:0, zero-extended opcode, and 0000h.
- R6: The 32-bit image is 54 word writes (108 bytes). The environment is fourteen words: control, 0, status, 0, tag, 0, data pointer low, data pointer high, instruction pointer low, instruction pointer high, zero-extended opcode, 0, 0, 0.
- R7: The stack follows the environment with no gap: ST(0) through ST(7), each as five words with the least significant word first. ST(k) sits at bits 80k+79:80k of st_i.
- R8: While mw_valid_o is high and mw_ready_i is low, mw_valid_o, mw_addr_o and mw_data_o hold their values into the next cycle.
- R9: In the cycle after the last write is accepted, done_o and ld_en_o pulse together with fault_code_o = 00. The load values are control 037Fh, status 0000h (condition flags cleared), tag FFFFh, and zero data pointer, instruction pointer and opcode. The saved status word keeps its condition flags.
- R10: A faulting sequence pulses done_o without ld_en_o, so the stub state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | ADDR_W | Byte base address of the image |
| size32_i | input | 1 | 1 selects the 32-bit image, 0 the 16-bit image |
| chk_wait_i | input | 1 | 1 selects the checking variant |
| fpu_idle_i | input | 1 | Earlier floating-point operations have retired |
| cr_i | input | CR_W | Control-register bits; bit 2 emulate, bit 3 task switched |
| pend_unmasked_i | input | 1 | Unmasked exception pending |
| cw_i | input | 16 | Control word |
| sw_i | input | 16 | Status word |
| tw_i | input | 16 | Tag word |
| dp_i | input | DP_W | Data pointer |
| ip_i | input | IP_W | Instruction pointer |
| op_i | input | OP_W | Last opcode |
| st_i | input | NREG*REG_W | Stack registers, ST(0) in the low bits |
| mw_valid_o | output | 1 | Write request valid |
| mw_addr_o | output | ADDR_W | Write byte address |
| mw_data_o | output | 16 | Write data |
| mw_ready_i | input | 1 | Write accepted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| fault_code_o | output | 2 | 00 none, 01 device not available, 10 math fault |
| ld_en_o | output | 1 | Load defaults into the stub |
| ld_cw_o | output | 16 | Default control word |
| ld_sw_o | output | 16 | Default status word |
| ld_tw_o | output | 16 | Default tag word |
| ld_dp_o | output | DP_W | Default data pointer |
| ld_ip_o | output | IP_W | Default instruction pointer |
| ld_op_o | output | OP_W | Default opcode |

## Verification
A wrong word index shows up at the very next accepted write as a wrong address or data word. It also shows up at done as a write count other than 47 or 54. A faulty state register that lets the sequence run ahead of the idle input, or past a fault, produces a write request within one cycle of the decision. A lost handshake stall changes the address or data while ready is low, visible in the following cycle. Missing defaults show as stub registers that still hold their old values in the cycle after done.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_HOLD, S_WRITE, S_FIN, S_FAULT
   } fsd_state_e;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_DNA  = 2'd1,
      FC_MATH = 2'd2
   } fsd_fault_e;

   localparam logic [15:0] CW_DEFAULT = 16'h037F;
   localparam logic [15:0] SW_DEFAULT = 16'h0000;
   localparam logic [15:0] TW_DEFAULT = 16'hFFFF;

   localparam int ENV16_WORDS = 7;
   localparam int ENV32_WORDS = 14;
endpackage

// File: rtl/fsd_fault_chk.sv
module fsd_fault_chk
   import fsd_pkg::*;
#(
   parameter int CR_W   = 4,
   parameter int EM_BIT = 2,
   parameter int TS_BIT = 3
) (
   input  logic [CR_W-1:0] cr_i,
   input  logic            chk_wait_i,
   input  logic            pend_i,
   output fsd_fault_e      code_o
);
   generate
      if (EM_BIT >= CR_W || TS_BIT >= CR_W) begin : g_bad_cr
         $error("fsd_fault_chk: control bit index outside CR_W");
      end
   endgenerate

   // Device-not-available outranks the math fault
   always_comb begin
      if (cr_i[EM_BIT] || cr_i[TS_BIT])
         code_o = FC_DNA;
      else if (chk_wait_i && pend_i)
         code_o = FC_MATH;
      else
         code_o = FC_NONE;
   end
endmodule

// File: rtl/fsd_word_sel.sv
module fsd_word_sel
   import fsd_pkg::*;
#(
   parameter int REG_W = 80,
   parameter int NREG  = 8,
   parameter int DP_W  = 32,
   parameter int IP_W  = 32,
   parameter int OP_W  = 11,
   parameter int IDX_W = 6
) (
   input  logic [IDX_W-1:0]       idx_i,
   input  logic                   size32_i,
   input  logic [15:0]            cw_i,
   input  logic [15:0]            sw_i,
   input  logic [15:0]            tw_i,
   input  logic [DP_W-1:0]        dp_i,
   input  logic [IP_W-1:0]        ip_i,
   input  logic [OP_W-1:0]        op_i,
   input  logic [NREG*REG_W-1:0]  st_i,
   output logic [15:0]            word_o
);
   localparam int STK_WORDS = NREG * (REG_W / 16);

   logic [15:0] st_words [STK_WORDS];
   logic [31:0] dp32, ip32;
   logic [15:0] op16;
   logic [IDX_W-1:0] env_n, stk_idx;

   // Stack words are contiguous because REG_W is a multiple of 16
   genvar g;
   generate
      for (g = 0; g < STK_WORDS; g++) begin : g_stk
         assign st_words[g] = st_i[g*16 +: 16];
      end
   endgenerate

   assign dp32    = 32'(dp_i);
   assign ip32    = 32'(ip_i);
   assign op16    = 16'(op_i);
   assign env_n   = size32_i ? IDX_W'(ENV32_WORDS) : IDX_W'(ENV16_WORDS);
   assign stk_idx = idx_i - env_n;

   always_comb begin
      word_o = '0;
      if (idx_i < env_n) begin
         if (size32_i) begin
            case (int'(idx_i))
               0:  word_o = cw_i;
               2:  word_o = sw_i;
               4:  word_o = tw_i;
               6:  word_o = dp32[15:0];
               7:  word_o = dp32[31:16];
               8:  word_o = ip32[15:0];
               9:  word_o = ip32[31:16];
               10: word_o = op16;
               default: word_o = '0;
            endcase
         end else begin
            case (int'(idx_i))
               0: word_o = cw_i;
               1: word_o = sw_i;
               2: word_o = tw_i;
               3: word_o = dp32[15:0];
               4: word_o = ip32[15:0];
               5: word_o = op16;
               default: word_o = '0;
            endcase
         end
      end else if (int'(stk_idx) < STK_WORDS) begin
         word_o = st_words[stk_idx];
      end
   end
endmodule

// File: rtl/fsd_state_dump.sv
module fsd_state_dump
   import fsd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 80,
   parameter int NREG   = 8,
   parameter int DP_W   = 32,
   parameter int IP_W   = 32,
   parameter int OP_W   = 11,
   parameter int CR_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [ADDR_W-1:0]      base_addr_i,
   input  logic                   size32_i,
   input  logic                   chk_wait_i,
   input  logic                   fpu_idle_i,
   input  logic [CR_W-1:0]        cr_i,
   input  logic                   pend_unmasked_i,
   input  logic [15:0]            cw_i,
   input  logic [15:0]            sw_i,
   input  logic [15:0]            tw_i,
   input  logic [DP_W-1:0]        dp_i,
   input  logic [IP_W-1:0]        ip_i,
   input  logic [OP_W-1:0]        op_i,
   input  logic [NREG*REG_W-1:0]  st_i,
   output logic                   mw_valid_o,
   output logic [ADDR_W-1:0]      mw_addr_o,
   output logic [15:0]            mw_data_o,
   input  logic                   mw_ready_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [1:0]             fault_code_o,
   output logic                   ld_en_o,
   output logic [15:0]            ld_cw_o,
   output logic [15:0]            ld_sw_o,
   output logic [15:0]            ld_tw_o,
   output logic [DP_W-1:0]        ld_dp_o,
   output logic [IP_W-1:0]        ld_ip_o,
   output logic [OP_W-1:0]        ld_op_o
);
   localparam int REG_WORDS = REG_W / 16;
   localparam int STK_WORDS = NREG * REG_WORDS;
   localparam int LAST16    = ENV16_WORDS + STK_WORDS - 1;
   localparam int LAST32    = ENV32_WORDS + STK_WORDS - 1;
   localparam int IDX_W     = $clog2(LAST32 + 1);

   generate
      if (REG_W % 16 != 0) begin : g_bad_reg
         $error("fsd_state_dump: REG_W must be a multiple of 16");
      end
      if (DP_W > 32 || IP_W > 32 || OP_W > 16) begin : g_bad_ptr
         $error("fsd_state_dump: pointer or opcode width too large");
      end
   endgenerate

   fsd_state_e       state_q;
   logic [IDX_W-1:0] idx_q, last_idx;
   logic [ADDR_W-1:0] base_q;
   logic             size32_q, wait_q;
   fsd_fault_e       code_q, chk_code;

   fsd_fault_chk #(.CR_W(CR_W), .EM_BIT(2), .TS_BIT(3)) u_fault (
      .cr_i       (cr_i),
      .chk_wait_i (wait_q),
      .pend_i     (pend_unmasked_i),
      .code_o     (chk_code)
   );

   fsd_word_sel #(
      .REG_W(REG_W), .NREG(NREG), .DP_W(DP_W), .IP_W(IP_W),
      .OP_W(OP_W), .IDX_W(IDX_W)
   ) u_sel (
      .idx_i    (idx_q),
      .size32_i (size32_q),
      .cw_i     (cw_i),
      .sw_i     (sw_i),
      .tw_i     (tw_i),
      .dp_i     (dp_i),
      .ip_i     (ip_i),
      .op_i     (op_i),
      .st_i     (st_i),
      .word_o   (mw_data_o)
   );

   assign last_idx = size32_q ? IDX_W'(LAST32) : IDX_W'(LAST16);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         idx_q    <= '0;
         base_q   <= '0;
         size32_q <= 1'b0;
         wait_q   <= 1'b0;
         code_q   <= FC_NONE;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               state_q  <= S_HOLD;
               base_q   <= base_addr_i;
               size32_q <= size32_i;
               wait_q   <= chk_wait_i;
               code_q   <= FC_NONE;
               idx_q    <= '0;
            end
            S_HOLD: if (fpu_idle_i) begin
               if (chk_code != FC_NONE) begin
                  code_q  <= chk_code;
                  state_q <= S_FAULT;
               end else begin
                  state_q <= S_WRITE;
               end
            end
            S_WRITE: if (mw_ready_i) begin
               if (idx_q == last_idx) state_q <= S_FIN;
               else                   idx_q   <= idx_q + 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o       = (state_q != S_IDLE);
   assign mw_valid_o   = (state_q == S_WRITE);
   assign mw_addr_o    = base_q + ADDR_W'({idx_q, 1'b0});
   assign done_o       = (state_q == S_FIN) || (state_q == S_FAULT);
   assign ld_en_o      = (state_q == S_FIN);
   assign fault_code_o = code_q;
   assign ld_cw_o      = CW_DEFAULT;
   assign ld_sw_o      = SW_DEFAULT;
   assign ld_tw_o      = TW_DEFAULT;
   assign ld_dp_o      = '0;
   assign ld_ip_o      = '0;
   assign ld_op_o      = '0;
endmodule

// File: rtl/fsd_dump_chk.sv
module fsd_dump_chk #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 80,
   parameter int NREG   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] base_addr_i,
   input logic              size32_i,
   input logic              fpu_idle_i,
   input logic              mw_valid_o,
   input logic [ADDR_W-1:0] mw_addr_o,
   input logic [15:0]       mw_data_o,
   input logic              mw_ready_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [1:0]        fault_code_o,
   input logic              ld_en_o
);
   localparam int STK_WORDS = NREG * (REG_W / 16);
   localparam int N16   = 7 + STK_WORDS;
   localparam int N32   = 14 + STK_WORDS;
   localparam int CNT_W = $clog2(N32 + 1) + 1;

   logic [ADDR_W-1:0] base_c;
   logic              size_c, idle_seen;
   logic [CNT_W-1:0]  wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_c    <= '0;
         size_c    <= 1'b0;
         idle_seen <= 1'b0;
         wr_cnt    <= '0;
      end else if (start_i && !busy_o) begin
         base_c    <= base_addr_i;
         size_c    <= size32_i;
         idle_seen <= 1'b0;
         wr_cnt    <= '0;
      end else begin
         if (busy_o && fpu_idle_i) idle_seen <= 1'b1;
         if (mw_valid_o && mw_ready_i) wr_cnt <= wr_cnt + 1'b1;
      end
   end

   assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_wait_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid_o |-> idle_seen);

   // R3 and R4: any fault code means nothing was written
   assert_fault_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_code_o != 2'b00) |-> (wr_cnt == '0));

   // R5 and R6: every address falls inside the image of the captured size
   assert_in_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid_o |-> ((mw_addr_o - base_c) < ADDR_W'(size_c ? 2*N32 : 2*N16)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid_o && !mw_ready_i) |=>
         (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o)));

   assert_done_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_code_o == 2'b00) |->
         (ld_en_o && wr_cnt == CNT_W'(size_c ? N32 : N16)));

   assert_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_code_o != 2'b00) |-> !ld_en_o);
endmodule

bind fsd_state_dump fsd_dump_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NREG(NREG)) u_chk (.*);

// File: tb/tb_fsd_state_dump.sv
`timescale 1ns/1ps
module tb_fsd_state_dump;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [31:0]  base_addr_i = '0;
   logic         size32_i = 1'b0, chk_wait_i = 1'b0, fpu_idle_i = 1'b1;
   logic [3:0]   cr_i = '0;
   logic         pend_unmasked_i = 1'b0;
   logic [15:0]  r_cw, r_sw, r_tw, e_cw, e_sw, e_tw;
   logic [31:0]  r_dp, r_ip, e_dp, e_ip;
   logic [10:0]  r_op, e_op;
   logic [639:0] st_flat;
   logic         mw_valid_o, mw_ready_i = 1'b1;
   logic [31:0]  mw_addr_o;
   logic [15:0]  mw_data_o;
   logic         busy_o, done_o, ld_en_o;
   logic [1:0]   fault_code_o;
   logic [15:0]  ld_cw_o, ld_sw_o, ld_tw_o;
   logic [31:0]  ld_dp_o, ld_ip_o;
   logic [10:0]  ld_op_o;

   fsd_state_dump dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .size32_i(size32_i), .chk_wait_i(chk_wait_i), .fpu_idle_i(fpu_idle_i),
      .cr_i(cr_i), .pend_unmasked_i(pend_unmasked_i),
      .cw_i(r_cw), .sw_i(r_sw), .tw_i(r_tw), .dp_i(r_dp), .ip_i(r_ip),
      .op_i(r_op), .st_i(st_flat),
      .mw_valid_o(mw_valid_o), .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o),
      .mw_ready_i(mw_ready_i), .busy_o(busy_o), .done_o(done_o),
      .fault_code_o(fault_code_o), .ld_en_o(ld_en_o),
      .ld_cw_o(ld_cw_o), .ld_sw_o(ld_sw_o), .ld_tw_o(ld_tw_o),
      .ld_dp_o(ld_dp_o), .ld_ip_o(ld_ip_o), .ld_op_o(ld_op_o)
   );

   int checks = 0, errors = 0, cyc = 0;
   logic [31:0] wr_addr [0:127];
   logic [15:0] wr_data [0:127];
   int   wr_n = 0, ld_cnt = 0, hold_bad = 0;
   bit   stall = 0, done_seen = 0, done_ld = 0, hv_prev = 0;
   logic [1:0]  done_code = '0;
   logic [31:0] ha = '0;
   logic [15:0] hd = '0;

   // Memory responder, stub register file and done monitor
   always @(negedge clk) begin
      bit rdy;
      cyc++;
      if (hv_prev && !(mw_valid_o && mw_addr_o == ha && mw_data_o == hd)) hold_bad++;
      rdy = stall ? (cyc % 3 != 0) : 1'b1;
      mw_ready_i = rdy;
      if (mw_valid_o && rdy && wr_n < 128) begin
         wr_addr[wr_n] = mw_addr_o;
         wr_data[wr_n] = mw_data_o;
         wr_n++;
      end
      hv_prev = mw_valid_o && !rdy;
      ha = mw_addr_o;
      hd = mw_data_o;
      if (done_o) begin
         done_seen = 1;
         done_code = fault_code_o;
         done_ld   = ld_en_o;
      end
      if (ld_en_o) begin
         ld_cnt++;
         r_cw = ld_cw_o; r_sw = ld_sw_o; r_tw = ld_tw_o;
         r_dp = ld_dp_o; r_ip = ld_ip_o; r_op = ld_op_o;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_state(input logic [15:0] seed);
      e_cw = 16'h0A72 ^ seed;
      e_sw = 16'h4700 | (seed & 16'h00FF);   // C0..C3 set
      e_tw = 16'h5A3C ^ seed;
      e_dp = 32'hDA7A_0000 | 32'(seed);
      e_ip = 32'h1B00_0000 | 32'(seed ^ 16'h00F1);
      e_op = 11'h5C3 ^ seed[10:0];
      r_cw = e_cw; r_sw = e_sw; r_tw = e_tw; r_dp = e_dp; r_ip = e_ip; r_op = e_op;
      for (int i = 0; i < 40; i++) st_flat[i*16 +: 16] = 16'(i * 16'h0123) ^ seed;
   endtask

   function automatic logic [15:0] exp_w(input bit s32, input int k);
      int envn = s32 ? 14 : 7;
      if (k >= envn) return st_flat[(k - envn)*16 +: 16];
      if (s32) begin
         case (k)
            0: return e_cw;  2: return e_sw;  4: return e_tw;
            6: return e_dp[15:0];  7: return e_dp[31:16];
            8: return e_ip[15:0];  9: return e_ip[31:16];
            10: return 16'(e_op);
            default: return 16'h0000;
         endcase
      end else begin
         case (k)
            0: return e_cw;  1: return e_sw;  2: return e_tw;
            3: return e_dp[15:0];  4: return e_ip[15:0];
            5: return 16'(e_op);
            default: return 16'h0000;
         endcase
      end
   endfunction

   task automatic begin_op(input logic [31:0] b, input bit s32, input bit w);
      @(negedge clk);
      wr_n = 0; done_seen = 0; done_ld = 0; ld_cnt = 0; hold_bad = 0;
      base_addr_i = b; size32_i = s32; chk_wait_i = w; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      while (!done_seen && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk(done_seen, req, "done reached", 64'(done_seen), 64'd1);
      @(negedge clk);
   endtask

   task automatic check_image(input logic [31:0] b, input bit s32, input string req);
      int n = s32 ? 54 : 47;
      int envn = s32 ? 14 : 7;
      chk(wr_n == n, req, "write count", 64'(wr_n), 64'(n));
      for (int k = 0; k < n && k < wr_n; k++) begin
         chk(wr_addr[k] == b + 32'(2*k), (k < envn) ? req : "R7", "address",
             64'(wr_addr[k]), 64'(b + 32'(2*k)));
         chk(wr_data[k] == exp_w(s32, k), (k < envn) ? req : "R7", "data word",
             64'(wr_data[k]), 64'(exp_w(s32, k)));
      end
   endtask

   task automatic check_reinit();
      chk(done_code == 2'b00 && done_ld && ld_cnt == 1, "R9", "done with load",
          64'({done_code, done_ld}), 64'd1);
      chk(r_cw == 16'h037F, "R9", "control default", 64'(r_cw), 64'h037F);
      chk(r_sw == 16'h0000, "R9", "status cleared", 64'(r_sw), 64'h0);
      chk(r_tw == 16'hFFFF, "R9", "tag default", 64'(r_tw), 64'hFFFF);
      chk(r_dp == 0 && r_ip == 0 && r_op == 0, "R9", "pointers cleared",
          {r_dp, r_ip}, 64'h0);
   endtask

   task automatic t_reset();
      chk(!busy_o && !mw_valid_o && !done_o && !ld_en_o && fault_code_o == 2'b00,
          "R1", "reset outputs", {59'd0, busy_o, mw_valid_o, done_o, ld_en_o, 1'b0}, 64'd0);
   endtask

   task automatic t_save(input logic [31:0] b, input bit s32, input bit w,
                         input bit st, input bit pend, input logic [15:0] seed);
      load_state(seed);
      stall = st;
      pend_unmasked_i = pend;
      begin_op(b, s32, w);
      wait_done(s32 ? "R6" : "R5");
      check_image(b, s32, s32 ? "R6" : "R5");
      chk(hold_bad == 0, "R8", "held under stall", 64'(hold_bad), 64'd0);
      if (pend) chk(done_code == 2'b00, "R4", "no-wait ignores pending", 64'(done_code), 64'd0);
      check_reinit();
      stall = 0;
      pend_unmasked_i = 1'b0;
   endtask

   task automatic t_fault(input logic [3:0] cr, input bit w, input bit pend,
                          input logic [1:0] exp_code, input string req);
      load_state(16'h3C5A);
      cr_i = cr;
      pend_unmasked_i = pend;
      begin_op(32'h0000_2000, 1'b1, w);
      wait_done(req);
      chk(done_code == exp_code, req, "fault code", 64'(done_code), 64'(exp_code));
      chk(wr_n == 0, req, "no writes on fault", 64'(wr_n), 64'd0);
      chk(!done_ld && ld_cnt == 0 && r_cw == e_cw && r_tw == e_tw, "R10",
          "state kept on fault", 64'(r_cw), 64'(e_cw));
      cr_i = '0;
      pend_unmasked_i = 1'b0;
   endtask

   task automatic t_idle_hold();
      int bad = 0;
      load_state(16'h1111);
      fpu_idle_i = 1'b0;
      begin_op(32'h0000_3000, 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) begin
         if (mw_valid_o || !busy_o || done_o) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R2", "held off until idle", 64'(bad), 64'd0);
      fpu_idle_i = 1'b1;
      wait_done("R2");
      check_image(32'h0000_3000, 1'b0, "R2");
   endtask

   task automatic t_busy_ignore();
      load_state(16'h0F0F);
      begin_op(32'h0000_4000, 1'b0, 1'b0);
      chk(busy_o, "R1", "busy after accept", 64'(busy_o), 64'd1);
      repeat (5) @(negedge clk);
      base_addr_i = 32'h0000_9000; size32_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done("R1");
      check_image(32'h0000_4000, 1'b0, "R1");
      chk(!busy_o, "R1", "idle after done", 64'(busy_o), 64'd0);
      check_reinit();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      load_state(16'h0000);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_save(32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
      t_save(32'h0000_1100, 1'b1, 1'b1, 1'b0, 1'b0, 16'h8E21);
      t_save(32'h0000_1200, 1'b0, 1'b1, 1'b1, 1'b0, 16'h5AA5);
      t_save(32'h0000_1300, 1'b1, 1'b0, 1'b1, 1'b1, 16'hC0DE);
      t_fault(4'b0100, 1'b1, 1'b1, 2'b01, "R3");
      t_fault(4'b1000, 1'b0, 1'b0, 2'b01, "R3");
      t_fault(4'b0000, 1'b1, 1'b1, 2'b10, "R4");
      t_idle_hold();
      t_busy_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule